// File: doc/BRIEF.md
# Reset Escalation and Status Unit

This unit sits beside a chip's reset generator. It records why resets happened and turns a run of repeated resets into a stronger response. Functional reset events arrive on a per-source vector, and a software-written disable mask decides which of them may request a functional reset. Destructive reset events arrive on a second vector. Every event is latched in a write-1-to-clear status register. A latched bit cannot be cleared while its source is still asserted.

Two 4-bit escalation thresholds shape the response. The functional threshold counts functional resets and turns the Nth one into a destructive reset. It returns to its power-up value of 15 on power-on reset and on every destructive reset. The destructive threshold counts destructive resets. Once the Nth one arrives, a hold-in-reset flag is raised and stays up until the next power-on reset, which is the only thing that clears this threshold. A value of 0 disables either threshold. The reset controller reads the request pulses and the hold flag. Software reaches the registers over a simple write port and a combinational read port.

Top module: `rst_escalation_unit`

## Requirements
- R1: After power-on reset (`por_n` low, asynchronous), the registers read as follows: destructive status 0x1 (bit 0 marks power-on), functional status 0, disable mask 0, functional counter 0, functional threshold 15 and destructive threshold 0. All outputs are low.
- R2: A rising edge on an enabled functional source i produces a one-cycle `func_rst_req` pulse. It also sets functional status bit i and adds one to the functional counter, which saturates at 15. A level held high gives only one pulse.
- R3: A rising edge on a functional source whose disable bit is 1 still sets its status bit. It requests no reset and leaves the counter unchanged.
- R4: When the functional threshold N is not 0, the functional reset that brings the count to N is promoted. It raises `dest_rst_req` instead of `func_rst_req` and sets destructive status bit 1. The threshold then returns to 15 and the counter to 0.
- R5: With a functional threshold of 0, no functional reset is ever promoted.
- R6: Any write to the functional threshold register restarts the functional counter at 0.
- R7: A rising edge on destructive source j raises a one-cycle `dest_rst_req` and sets destructive status bit j+2. It restores the functional threshold to 15 and clears the functional counter, and it leaves the destructive threshold unchanged. It takes priority over a functional edge in the same cycle, so the two requests are never high together.
- R8: When the destructive threshold N is not 0, the Nth destructive reset since power-on sets `hold_rst`. `hold_rst` stays high, and no further request is issued, until `por_n` is asserted.
- R9: With a destructive threshold of 0, `hold_rst` never rises.
- R10: Writing 1 to a status bit clears it unless its source is asserted in that cycle, in which case the bit stays set. Written zeros have no effect.
- R11: `irq` is high whenever some functional status bit is set together with its disable bit.
- R12: The register offsets are: destructive status 0x00, functional status 0x08, disable mask 0x0C, functional counter 0x14 (read only), functional threshold 0x18 and destructive threshold 0x1C. `rd_data` follows `rd_addr` in the same cycle, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| dest_evt | input | DEV_N | Destructive event sources (level) |
| func_evt | input | FEV_N | Functional event sources (level) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Write byte offset |
| reg_wdata | input | DATA_W | Write data |
| rd_addr | input | 6 | Read byte offset |
| rd_data | output | DATA_W | Read data, combinational |
| func_rst_req | output | 1 | Functional reset request pulse |
| dest_rst_req | output | 1 | Destructive reset request pulse |
| hold_rst | output | 1 | Hold chip in reset |
| irq | output | 1 | Disabled-source-pending interrupt |

## Verification
Every registered result, including request pulses, status bits, counters, thresholds and the hold flag, is due at the first rising edge after the stimulus is presented. `irq` and `rd_data` follow that state combinationally in the same cycle. Inputs change away from the active edge. A behavioural model advances on the same rising edge, and all outputs and every register, swept through the read port, are compared with the model at the following falling edge. Directed checks at the boundaries use pulse counts taken at those same falling edges, so each result is compared exactly one edge after it was caused.

// File: rtl/rsu_pkg.sv
`timescale 1ns/1ps
package rsu_pkg;
  localparam int ADDR_W = 6;
  localparam int ESC_W  = 4;
  localparam logic [ADDR_W-1:0] A_DES  = 6'h00;
  localparam logic [ADDR_W-1:0] A_FES  = 6'h08;
  localparam logic [ADDR_W-1:0] A_FDIS = 6'h0C;
  localparam logic [ADDR_W-1:0] A_FCNT = 6'h14;
  localparam logic [ADDR_W-1:0] A_FTHR = 6'h18;
  localparam logic [ADDR_W-1:0] A_DTHR = 6'h1C;
  localparam logic [ESC_W-1:0]  FTHR_PON = '1;
  localparam logic [ESC_W-1:0]  DTHR_PON = '0;
endpackage

// File: rtl/rsu_status.sv
`timescale 1ns/1ps
module rsu_status #(
  parameter int W = 4,
  parameter logic [W-1:0] PON_VAL = '0
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] src,
  input  logic         clr_we,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] stat
);
  logic [W-1:0] clr_eff;
  assign clr_eff = clr_we ? clr_mask : '0;

  // setting wins over clearing, so an active source keeps its bit
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) stat <= PON_VAL;
    else        stat <= (stat & ~clr_eff) | src;
  end

  // R10
  src_holds_chk: assert property (@(posedge clk) disable iff (!por_n)
    (src != '0) |=> ((stat & $past(src)) == $past(src)));
endmodule

// File: rtl/rsu_func_esc.sv
`timescale 1ns/1ps
module rsu_func_esc import rsu_pkg::*; #(
  parameter int CW = ESC_W,
  parameter logic [CW-1:0] PON_THR = '1
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          hit,
  input  logic          ext_dest,
  input  logic          hold,
  input  logic          thr_we,
  input  logic [CW-1:0] thr_wdata,
  output logic          promote,
  output logic          req,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] thr
);
  logic          take;
  logic [CW:0]   nxt;

  assign take    = hit & ~hold & ~ext_dest;
  assign nxt     = {1'b0, cnt} + (CW+1)'(1);
  assign promote = take & (thr != '0) & (nxt >= {1'b0, thr});

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt <= '0;
      thr <= PON_THR;
      req <= 1'b0;
    end else begin
      req <= take & ~promote;
      if (thr_we) begin
        thr <= thr_wdata;
        cnt <= '0;
      end else if (ext_dest | promote) begin
        thr <= PON_THR;
        cnt <= '0;
      end else if (take && !(&cnt)) begin
        cnt <= nxt[CW-1:0];
      end
    end
  end

  // R6
  thr_write_restart_chk: assert property (@(posedge clk) disable iff (!por_n)
    thr_we |=> (cnt == '0));
  // R4
  promote_rearm_chk: assert property (@(posedge clk) disable iff (!por_n)
    (promote && !thr_we) |=> (thr == PON_THR && cnt == '0 && !req));
endmodule

// File: rtl/rsu_dest_esc.sv
`timescale 1ns/1ps
module rsu_dest_esc import rsu_pkg::*; #(
  parameter int CW = ESC_W,
  parameter logic [CW-1:0] PON_THR = '0
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          fire,
  input  logic          thr_we,
  input  logic [CW-1:0] thr_wdata,
  output logic          req,
  output logic          hold,
  output logic [CW-1:0] thr
);
  logic [CW-1:0] cnt;
  logic [CW:0]   nxt;
  logic          go;

  assign go  = fire & ~hold;
  assign nxt = {1'b0, cnt} + (CW+1)'(1);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt  <= '0;
      thr  <= PON_THR;
      req  <= 1'b0;
      hold <= 1'b0;
    end else begin
      req <= go;
      if (thr_we) thr <= thr_wdata;
      if (go) begin
        if (!(&cnt)) cnt <= nxt[CW-1:0];
        if ((thr != '0) && (nxt >= {1'b0, thr})) hold <= 1'b1;
      end
    end
  end

  // R8
  hold_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    hold |=> hold);
  // R8
  no_req_in_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    hold |=> !req);
  // R9
  thr_zero_no_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (thr == '0 && !hold) |=> !hold);
endmodule

// File: rtl/rst_escalation_unit.sv
`timescale 1ns/1ps
module rst_escalation_unit import rsu_pkg::*; #(
  parameter int DEV_N = 3,
  parameter int FEV_N = 4,
  localparam int DES_W  = DEV_N + 2,
  localparam int DATA_W = (DES_W > FEV_N) ? DES_W : FEV_N
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic [DEV_N-1:0]  dest_evt,
  input  logic [FEV_N-1:0]  func_evt,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              func_rst_req,
  output logic              dest_rst_req,
  output logic              hold_rst,
  output logic              irq
);
  logic [FEV_N-1:0] fev_q, f_rise, f_take, fes, fdis;
  logic [DEV_N-1:0] dev_q, d_rise;
  logic [DES_W-1:0] des;
  logic [ESC_W-1:0] fcnt, fthr, dthr;
  logic             ext_dest, promote;
  logic             we_des, we_fes, we_fdis, we_fthr, we_dthr;

  assign we_des  = reg_we && (reg_addr == A_DES);
  assign we_fes  = reg_we && (reg_addr == A_FES);
  assign we_fdis = reg_we && (reg_addr == A_FDIS);
  assign we_fthr = reg_we && (reg_addr == A_FTHR);
  assign we_dthr = reg_we && (reg_addr == A_DTHR);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      fev_q <= '0;
      dev_q <= '0;
      fdis  <= '0;
    end else begin
      fev_q <= func_evt;
      dev_q <= dest_evt;
      if (we_fdis) fdis <= reg_wdata[FEV_N-1:0];
    end
  end

  assign f_rise   = func_evt & ~fev_q;
  assign f_take   = f_rise & ~fdis;
  assign d_rise   = dest_evt & ~dev_q;
  assign ext_dest = (|d_rise) & ~hold_rst;

  rsu_status #(.W(FEV_N), .PON_VAL('0)) u_fes (
    .clk(clk), .por_n(por_n), .src(func_evt),
    .clr_we(we_fes), .clr_mask(reg_wdata[FEV_N-1:0]), .stat(fes));

  rsu_status #(.W(DES_W), .PON_VAL(DES_W'(1))) u_des (
    .clk(clk), .por_n(por_n), .src({dest_evt, promote, 1'b0}),
    .clr_we(we_des), .clr_mask(reg_wdata[DES_W-1:0]), .stat(des));

  rsu_func_esc #(.CW(ESC_W), .PON_THR(FTHR_PON)) u_fesc (
    .clk(clk), .por_n(por_n), .hit(|f_take), .ext_dest(ext_dest),
    .hold(hold_rst), .thr_we(we_fthr), .thr_wdata(reg_wdata[ESC_W-1:0]),
    .promote(promote), .req(func_rst_req), .cnt(fcnt), .thr(fthr));

  rsu_dest_esc #(.CW(ESC_W), .PON_THR(DTHR_PON)) u_desc (
    .clk(clk), .por_n(por_n), .fire(ext_dest | promote),
    .thr_we(we_dthr), .thr_wdata(reg_wdata[ESC_W-1:0]),
    .req(dest_rst_req), .hold(hold_rst), .thr(dthr));

  assign irq = |(fes & fdis);

  always_comb begin
    case (rd_addr)
      A_DES:   rd_data = DATA_W'(des);
      A_FES:   rd_data = DATA_W'(fes);
      A_FDIS:  rd_data = DATA_W'(fdis);
      A_FCNT:  rd_data = DATA_W'(fcnt);
      A_FTHR:  rd_data = DATA_W'(fthr);
      A_DTHR:  rd_data = DATA_W'(dthr);
      default: rd_data = '0;
    endcase
  end

  // R7
  one_req_chk: assert property (@(posedge clk) disable iff (!por_n)
    !(func_rst_req && dest_rst_req));
  // R3
  disabled_no_req_chk: assert property (@(posedge clk) disable iff (!por_n)
    (f_take == '0) |=> !func_rst_req);
endmodule

// File: tb/rst_escalation_unit_tb_top.sv
`timescale 1ns/1ps
module rst_escalation_unit_tb_top;
  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic [2:0] dest_evt = '0;
  logic [3:0] func_evt = '0;
  logic       reg_we = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [4:0] reg_wdata = '0;
  logic [5:0] rd_addr = '0;
  logic [4:0] rd_data;
  logic       func_rst_req, dest_rst_req, hold_rst, irq;

  always #2.5 clk = ~clk;

  rst_escalation_unit dut_i (
    .clk(clk), .por_n(por_n), .dest_evt(dest_evt), .func_evt(func_evt),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data), .func_rst_req(func_rst_req),
    .dest_rst_req(dest_rst_req), .hold_rst(hold_rst), .irq(irq));

  int    checks = 0, failures = 0;
  string cur_req = "R1";

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", cur_req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_des, m_fes, m_dis, m_fcnt, m_fthr, m_dthr, m_dcnt, m_pf, m_pd;
  bit m_hold, m_freq, m_dreq;

  always @(posedge clk or negedge por_n) begin
    int fnew, en, dnew;
    bit ext, hit, prom, fire;
    if (!por_n) begin
      m_des = 1; m_fes = 0; m_dis = 0; m_fcnt = 0; m_fthr = 15; m_dthr = 0;
      m_dcnt = 0; m_pf = 0; m_pd = 0; m_hold = 0; m_freq = 0; m_dreq = 0;
    end else begin
      fnew = int'(func_evt) & ~m_pf;
      en   = fnew & ~m_dis;
      dnew = int'(dest_evt) & ~m_pd;
      ext  = (dnew != 0) && !m_hold;
      hit  = (en != 0) && !m_hold && !ext;
      prom = hit && (m_fthr != 0) && (m_fcnt + 1 >= m_fthr);
      fire = ext || prom;
      m_freq = hit && !prom;
      m_dreq = fire;
      if (fire) begin
        if (m_dthr != 0 && m_dcnt + 1 >= m_dthr) m_hold = 1;
        if (m_dcnt < 15) m_dcnt++;
      end
      if (reg_we && reg_addr == 6'h18) begin
        m_fthr = int'(reg_wdata) & 15; m_fcnt = 0;
      end else if (fire) begin
        m_fthr = 15; m_fcnt = 0;
      end else if (hit && m_fcnt < 15) m_fcnt++;
      if (reg_we && reg_addr == 6'h1C) m_dthr = int'(reg_wdata) & 15;
      if (reg_we && reg_addr == 6'h0C) m_dis = int'(reg_wdata) & 15;
      if (reg_we && reg_addr == 6'h08) m_fes &= ~int'(reg_wdata);
      if (reg_we && reg_addr == 6'h00) m_des &= ~int'(reg_wdata);
      m_fes |= int'(func_evt);
      m_des |= (int'(dest_evt) << 2) | (int'(prom) << 1);
      m_pf = int'(func_evt);
      m_pd = int'(dest_evt);
    end
  end

  function automatic int exp_rd(logic [5:0] a);
    case (a)
      6'h00: return m_des;
      6'h08: return m_fes;
      6'h0C: return m_dis;
      6'h14: return m_fcnt;
      6'h18: return m_fthr;
      6'h1C: return m_dthr;
      default: return 0;
    endcase
  endfunction

  // ---------------- per-clock comparison ----------------
  logic [5:0] addrs [7] = '{6'h00, 6'h08, 6'h0C, 6'h14, 6'h18, 6'h1C, 6'h04};
  int snap [7];
  int freq_seen = 0, dreq_seen = 0;
  bit irq_snap, hold_snap;

  always @(negedge clk) begin
    for (int i = 0; i < 7; i++) begin
      rd_addr = addrs[i];
      #0.2;
      snap[i] = int'(rd_data);
      chk($sformatf("rd@%0h", addrs[i]), snap[i], exp_rd(addrs[i]));
    end
    chk("func_rst_req", int'(func_rst_req), int'(m_freq));
    chk("dest_rst_req", int'(dest_rst_req), int'(m_dreq));
    chk("hold_rst", int'(hold_rst), int'(m_hold));
    chk("irq", int'(irq), int'((m_fes & m_dis) != 0));
    freq_seen += int'(func_rst_req);
    dreq_seen += int'(dest_rst_req);
    irq_snap  = irq;
    hold_snap = hold_rst;
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(int n);
    repeat (n) begin @(negedge clk); #2; end
  endtask
  task automatic wr(logic [5:0] a, logic [4:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_we = 1'b0;
  endtask
  task automatic fpulse(int idx, int len);
    func_evt[idx] = 1'b1; step(len); func_evt[idx] = 1'b0; step(1);
  endtask
  task automatic dpulse(int idx);
    dest_evt[idx] = 1'b1; step(1); dest_evt[idx] = 1'b0; step(1);
  endtask
  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired act=0 exp=1");
    finish_run();
  end

  initial begin
    int f0, d0;
    step(3);
    // R1 reset values
    cur_req = "R1";
    chk("des pon", snap[0], 1); chk("fthr pon", snap[4], 15);
    chk("dthr pon", snap[5], 0); chk("fes pon", snap[1], 0);
    por_n = 1'b1;
    step(2);
    // R12 unmapped offset reads zero
    cur_req = "R12";
    chk("unmapped 0x04", snap[6], 0);
    // R10 clear the power-on flag
    cur_req = "R10";
    wr(6'h00, 5'h01);
    chk("des after w1c", snap[0], 0);
    // R2 enabled functional edge, held level gives one pulse
    cur_req = "R2";
    f0 = freq_seen;
    fpulse(1, 3);
    chk("one func pulse", freq_seen - f0, 1);
    chk("fcnt after one", snap[3], 1);
    chk("fes bit1", snap[1], 2);
    // R3 disabled source
    cur_req = "R3";
    wr(6'h0C, 5'h04);
    f0 = freq_seen;
    fpulse(2, 1);
    chk("no req when disabled", freq_seen - f0, 0);
    chk("fcnt unchanged", snap[3], 1);
    chk("fes bit2 set", snap[1] & 4, 4);
    // R11 interrupt
    cur_req = "R11";
    chk("irq high", int'(irq_snap), 1);
    wr(6'h08, 5'h04);
    chk("irq low after clear", int'(irq_snap), 0);
    wr(6'h0C, 5'h00);
    // R10 clear blocked while source active, zeros ignored
    cur_req = "R10";
    func_evt[0] = 1'b1; step(1);
    wr(6'h08, 5'h01);
    chk("bit0 kept while active", snap[1] & 1, 1);
    func_evt[0] = 1'b0; step(1);
    wr(6'h08, 5'h00);
    chk("zero write no effect", snap[1], 3);
    wr(6'h08, 5'h01);
    chk("bit0 cleared", snap[1], 2);
    // R6 threshold write restarts counter
    cur_req = "R6";
    wr(6'h18, 5'h03);
    chk("fcnt restart", snap[3], 0);
    chk("fthr written", snap[4], 3);
    // R4 third functional reset is promoted
    cur_req = "R4";
    f0 = freq_seen; d0 = dreq_seen;
    fpulse(0, 1); fpulse(0, 1); fpulse(0, 1);
    chk("two func reqs", freq_seen - f0, 2);
    chk("one dest req", dreq_seen - d0, 1);
    chk("escalation flag", snap[0] & 2, 2);
    chk("fthr rearmed", snap[4], 15);
    chk("fcnt cleared", snap[3], 0);
    // R5 threshold zero never promotes, counter saturates
    cur_req = "R5";
    wr(6'h18, 5'h00);
    f0 = freq_seen; d0 = dreq_seen;
    for (int k = 0; k < 17; k++) fpulse(3, 1);
    chk("all functional", freq_seen - f0, 17);
    chk("no promotion", dreq_seen - d0, 0);
    chk("fcnt saturates", snap[3], 15);
    // R7 destructive edge wins over functional edge
    cur_req = "R7";
    f0 = freq_seen; d0 = dreq_seen;
    func_evt[3] = 1'b1; dest_evt[1] = 1'b1; step(1);
    func_evt[3] = 1'b0; dest_evt[1] = 1'b0; step(1);
    chk("dest only", dreq_seen - d0, 1);
    chk("no func", freq_seen - f0, 0);
    chk("des bit3", snap[0] & 8, 8);
    chk("fthr restored", snap[4], 15);
    chk("fcnt zero", snap[3], 0);
    // R9 threshold zero never holds
    cur_req = "R9";
    dpulse(0); dpulse(2);
    chk("no hold", int'(hold_snap), 0);
    // R8 hold at Nth destructive reset (count now 4)
    cur_req = "R8";
    wr(6'h1C, 5'h06);
    dpulse(0);
    chk("not yet held", int'(hold_snap), 0);
    d0 = dreq_seen;
    dpulse(1);
    chk("held", int'(hold_snap), 1);
    chk("last dest req", dreq_seen - d0, 1);
    f0 = freq_seen; d0 = dreq_seen;
    dpulse(2); fpulse(1, 1);
    chk("no reqs in hold", (freq_seen - f0) + (dreq_seen - d0), 0);
    chk("still held", int'(hold_snap), 1);
    por_n = 1'b0; step(2); por_n = 1'b1; step(1);
    chk("hold released by por", int'(hold_snap), 0);
    chk("dthr cleared by por", snap[5], 0);
    chk("des por flag", snap[0], 1);
    finish_run();
  end
endmodule